// File: doc/BRIEF.md
# Privileged Interrupt Context Register Window

This block holds the 64-byte interrupt context of one processor thread. The context is split into four 16-byte rings: user (ring 0), OS (ring 1), pool (ring 2) and physical (ring 3). Software reaches the context through a memory-mapped window of four privilege pages. Page 0 (hardware) is the most privileged, then page 1 (hypervisor), page 2 (OS) and page 3 (user). Every page filters each byte of an access through its own read and write permissions.

Within each page, the lower half (address bit 11 clear) gives raw, byte-masked, big-endian loads and stores of the context bytes. It also holds one special store: the OS current-priority write. The upper half (bit 11 set) holds only special operations. An access there that matches no operation is an error and never falls through to a raw access.

Requests are one per cycle. The response (valid, data, error) is registered and appears on the cycle after the request.

Top module: `intctx_window`

## Requirements
- R1: During and after reset every context byte is 0x00, except bytes 0x13, 0x14 and 0x16 of the OS ring, which are 0xFF. A page-0 8-byte raw read at offset 0x010 after reset returns 0x000000FFFF000000.
- R2: The page is `req_addr[PAGE_SHIFT+1:PAGE_SHIFT]`. The context byte offset is `req_addr[5:0]`, and bits 10:6 of the address do not alter a raw access. The ring is offset bits 5:4.
- R3: For an access of N bytes, context byte `(offset+i) mod 64` maps to data lane N-1-i, so the lowest offset lands in the most significant byte.
  - Permissions are given per page as 16-bit masks, one per ring, where bit k stands for byte k of that ring.
  - Page 0: read and write masks are 0x0F01, 0x0FBF, 0x0F0C and 0x79AF for rings 0 to 3.
  - Page 1: read and write masks are 0x0F01, 0x0FBF, 0x0E0C and 0x09AF.
  - Page 2: ring 0 has read and write mask 0x0F01; ring 1 has read mask 0x00BF and write mask 0x0002; rings 2 and 3 have no access.
  - Page 3: only ring-0 byte 0 is readable and writable.
  - A legal raw read returns the readable bytes and zero in every other lane.
- R4: A legal raw write updates only the bytes writable from the accessing page and leaves every other byte unchanged.
- R5: A raw access whose size is not 4 or 8 bytes is illegal.
- R6: A raw access whose starting offset lies in the user ring (offset bits 5:4 = 0) is illegal.
- R7: A raw access in which no byte is permitted for its direction is illegal.
- R8: Every illegal access, or every access in the upper half that matches no operation, behaves as follows:
  - It raises `rsp_err` and changes no state.
  - A read returns all ones.
  - A write returns zero data.
- R9: A 1-byte write at 12-bit offset 0x011 from page 0, 1 or 2 sets the OS current priority (context byte 0x11) to `req_wdata[7:0]`, or to 0xFF when that value exceeds MAX_PRIO (7). No error is raised.
- R10: A 2-byte read at 12-bit offset 0x810 from page 0, 1 or 2 is the OS acknowledge. It returns zero, raises no error and changes no state.
- R11: Page 3 may not use either special operation. In the upper half the access is an error. At offset 0x011 it falls to the raw rules, where a 1-byte size makes it illegal.
- R12: `rsp_valid` is high exactly on the cycle after a cycle with `req_valid` high. `rsp_rdata` and `rsp_err` describe that request on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+2 | Window offset: page index above PAGE_SHIFT, operation half in bit 11 |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_wdata | input | 64 | Store data, right-aligned, big-endian lane order |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Load data, right-aligned |
| rsp_err | output | 1 | Request was illegal or matched no operation |

## Verification
The hardest state to reach is one where a store's effect is visible only through a different page's read mask. Two cases stand out: a clamped priority stored by the special write, and a hardware-page write to a pool byte that the hypervisor page hides. The stimulus mixes random accesses over all pages, both halves, every size and offsets with stray bits 10:6. Directed sequences write through one page and read back through another, so that each masked or clamped byte is brought out at the ports. Wrapping 8-byte accesses near offset 0x3F and special operations attempted from the user page are also produced on purpose.

// File: rtl/intctx_window.sv
module intctx_window #(
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_PRIO   = 7,
  localparam int AW        = PAGE_SHIFT + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_size,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_err
);

  localparam logic [11:0] CPPR_OFF = 12'h011;
  localparam logic [11:0] ACK_OFF  = 12'h810;
  localparam int          CPPR_IDX = 17;
  localparam logic [7:0]  PRIO_TOP = 8'(MAX_PRIO);

  logic [7:0] regs [64];

  function automatic logic [1:0] perm(input logic [1:0] pg, input logic [5:0] b);
    logic [15:0] rm, wm;
    rm = '0;
    wm = '0;
    case (pg)
      2'd0: begin
        case (b[5:4])
          2'd0: rm = 16'h0F01;
          2'd1: rm = 16'h0FBF;
          2'd2: rm = 16'h0F0C;
          default: rm = 16'h79AF;
        endcase
        wm = rm;
      end
      2'd1: begin
        case (b[5:4])
          2'd0: rm = 16'h0F01;
          2'd1: rm = 16'h0FBF;
          2'd2: rm = 16'h0E0C;
          default: rm = 16'h09AF;
        endcase
        wm = rm;
      end
      2'd2: begin
        case (b[5:4])
          2'd0: begin rm = 16'h0F01; wm = 16'h0F01; end
          2'd1: begin rm = 16'h00BF; wm = 16'h0002; end
          default: ;
        endcase
      end
      default: begin
        if (b[5:4] == 2'd0) begin
          rm = 16'h0001;
          wm = 16'h0001;
        end
      end
    endcase
    return {rm[b[3:0]], wm[b[3:0]]};
  endfunction

  wire [1:0]  page = req_addr[PAGE_SHIFT +: 2];
  wire [11:0] off  = req_addr[11:0];
  wire [5:0]  roff = req_addr[5:0];
  wire        spc  = req_addr[11];

  logic [5:0]  idx  [8];
  logic [2:0]  lane [8];
  logic [7:0]  wb   [8];
  logic [7:0]  bm;
  logic [1:0]  pc;
  logic [63:0] rd_raw;

  always_comb begin
    bm     = '0;
    rd_raw = '0;
    pc     = '0;
    for (int i = 0; i < 8; i++) begin
      idx[i]  = roff + 6'(i);
      lane[i] = 3'(req_size - 4'd1 - 4'(i));
      wb[i]   = req_wdata[{lane[i], 3'b000} +: 8];
      pc      = perm(page, idx[i]);
      if (4'(i) < req_size) bm[i] = req_write ? pc[0] : pc[1];
      if (bm[i]) rd_raw[{lane[i], 3'b000} +: 8] = regs[idx[i]];
    end
  end

  wire size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
  wire raw_ok   = size_ok && (|bm) && (roff[5:4] != 2'd0);
  wire priv_ok  = (page != 2'd3);
  wire cppr_hit = !spc && req_write && (off == CPPR_OFF) && (req_size == 4'd1) && priv_ok;
  wire ack_hit  = spc && !req_write && (off == ACK_OFF) && (req_size == 4'd2) && priv_ok;
  wire err      = spc ? !ack_hit : !(cppr_hit || raw_ok);

  wire [63:0] rd_val   = err ? '1 : (ack_hit ? 64'd0 : rd_raw);
  wire [7:0]  cppr_new = (req_wdata[7:0] > PRIO_TOP) ? 8'hFF : req_wdata[7:0];

  logic rsp_rd, rsp_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) regs[k] <= 8'h00;
      regs[8'h13] <= 8'hFF;
      regs[8'h14] <= 8'hFF;
      regs[8'h16] <= 8'hFF;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      rsp_rd    <= 1'b0;
      rsp_ack   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err   <= err;
        rsp_rdata <= req_write ? 64'd0 : rd_val;
        rsp_rd    <= !req_write;
        rsp_ack   <= ack_hit;
        if (req_write && !err) begin
          if (cppr_hit) regs[CPPR_IDX] <= cppr_new;
          else begin
            for (int i = 0; i < 8; i++)
              if (bm[i]) regs[idx[i]] <= wb[i];
          end
        end
      end
    end
  end

  logic [511:0] flat;
  always_comb
    for (int k = 0; k < 64; k++) flat[8*k +: 8] = regs[k];

  // R8
  err_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && rsp_rd) |-> (rsp_rdata == '1));

  // R4
  no_store_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(flat));

  // R6
  user_ring_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !spc && roff[5:4] == 2'd0) |=> $stable(flat));

  // R9
  cppr_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cppr_hit) |=> (regs[CPPR_IDX] <= PRIO_TOP || regs[CPPR_IDX] == 8'hFF));

  // R10
  ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |-> (rsp_rdata == 64'd0 && !rsp_err));

endmodule

// File: tb/sim_intctx_window.sv
module sim_intctx_window;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  intctx_window u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m [64];

  function automatic logic [1:0] mperm(input logic [1:0] pg, input logic [5:0] b);
    logic [15:0] r, w;
    r = '0; w = '0;
    if (pg == 2'd0) begin
      r = (b[5:4] == 0) ? 16'h0F01 : (b[5:4] == 1) ? 16'h0FBF : (b[5:4] == 2) ? 16'h0F0C : 16'h79AF;
      w = r;
    end else if (pg == 2'd1) begin
      r = (b[5:4] == 0) ? 16'h0F01 : (b[5:4] == 1) ? 16'h0FBF : (b[5:4] == 2) ? 16'h0E0C : 16'h09AF;
      w = r;
    end else if (pg == 2'd2) begin
      if (b[5:4] == 0) begin r = 16'h0F01; w = 16'h0F01; end
      if (b[5:4] == 1) begin r = 16'h00BF; w = 16'h0002; end
    end else if (b[5:4] == 0) begin
      r = 16'h0001; w = 16'h0001;
    end
    return {r[b[3:0]], w[b[3:0]]};
  endfunction

  task automatic mreset;
    for (int k = 0; k < 64; k++) m[k] = 8'h00;
    m[8'h13] = 8'hFF; m[8'h14] = 8'hFF; m[8'h16] = 8'hFF;
  endtask

  task automatic model(input bit wr, input logic [13:0] a, input logic [3:0] sz,
                       input logic [63:0] wd, output logic [63:0] er, output bit ee);
    logic [1:0] pg;
    logic [5:0] ro, b;
    logic [1:0] p;
    int n;
    bit any;
    pg = a[13:12]; ro = a[5:0]; n = int'(sz);
    er = 64'd0; ee = 1'b0;
    if (a[11]) begin
      if (!wr && a[11:0] == 12'h810 && n == 2 && pg != 3) return;
      ee = 1'b1; er = wr ? 64'd0 : '1;
      return;
    end
    if (wr && a[11:0] == 12'h011 && n == 1 && pg != 3) begin
      m[17] = (wd[7:0] > 8'd7) ? 8'hFF : wd[7:0];
      return;
    end
    any = 1'b0;
    for (int i = 0; i < n; i++) begin
      b = 6'(ro + 6'(i)); p = mperm(pg, b);
      if (wr ? p[0] : p[1]) any = 1'b1;
    end
    if (!((n == 4 || n == 8) && any && ro[5:4] != 2'd0)) begin
      ee = 1'b1; er = wr ? 64'd0 : '1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      b = 6'(ro + 6'(i)); p = mperm(pg, b);
      if (wr && p[0]) m[b] = wd[8*(n-1-i) +: 8];
      if (!wr && p[1]) er[8*(n-1-i) +: 8] = m[b];
    end
  endtask

  task automatic xfer(input bit wr, input logic [13:0] a, input logic [3:0] sz,
                      input logic [63:0] wd, input string tag);
    logic [63:0] er;
    bit ee;
    model(wr, a, sz, wd, er, ee);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_rdata !== er || rsp_err !== ee) begin
      fails++;
      $display("FAIL %s: addr=%h wr=%0b size=%0d got valid=%0b data=%h err=%0b, expected valid=1 data=%h err=%0b",
               tag, a, wr, sz, rsp_valid, rsp_rdata, rsp_err, er, ee);
    end
  endtask

  task automatic expect_val(input logic [63:0] got, input logic [63:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  function automatic string tag_of(input bit wr, input logic [13:0] a, input logic [3:0] sz);
    if (a[11]) return (a[11:0] == 12'h810) ? "R10" : "R8";
    if (a[11:0] == 12'h011 && sz == 1) return (a[13:12] == 3) ? "R11" : "R9";
    if (sz != 4 && sz != 8) return "R5";
    if (a[5:4] == 0) return "R6";
    return wr ? "R4" : "R3";
  endfunction

  initial begin
    logic [13:0] a;
    logic [3:0] sz;
    bit wr;
    int k;
    void'($urandom(32'd2024));
    mreset();
    repeat (3) @(negedge clk);
    expect_val({63'd0, rsp_valid}, 64'd0, "R12 reset valid");
    rst_n = 1'b1;

    xfer(0, 14'h0010, 4'd8, 0, "R1");
    expect_val(u0.rsp_rdata, 64'h000000FFFF000000, "R1 reset context");
    @(negedge clk);
    expect_val({63'd0, rsp_valid}, 64'd0, "R12 idle valid");

    xfer(0, 14'h3000, 4'd4, 0, "R6");
    xfer(0, 14'h0010, 4'd2, 0, "R5");
    xfer(1, 14'h2020, 4'd4, 64'h01020304, "R7");
    xfer(1, 14'h2010, 4'd4, 64'hAABBCCDD, "R4");
    xfer(0, 14'h0010, 4'd4, 0, "R4");
    expect_val(rsp_rdata, 64'h00BB00FF, "R4 only byte 0x11 written");
    xfer(1, 14'h2011, 4'd1, 64'h09, "R9");
    xfer(0, 14'h2010, 4'd4, 0, "R9");
    expect_val(rsp_rdata, 64'h00FF00FF, "R9 clamp");
    xfer(1, 14'h1011, 4'd1, 64'h05, "R9");
    xfer(0, 14'h2010, 4'd4, 0, "R9");
    xfer(1, 14'h3011, 4'd1, 64'h02, "R11");
    xfer(0, 14'h3810, 4'd2, 0, "R11");
    xfer(0, 14'h1810, 4'd2, 0, "R10");
    xfer(1, 14'h0810, 4'd2, 0, "R8");
    xfer(0, 14'h0800, 4'd8, 0, "R8");
    xfer(0, 14'h2010, 4'd4, 0, "R10");
    xfer(1, 14'h0028, 4'd4, 64'h11223344, "R2");
    xfer(0, 14'h1028, 4'd4, 0, "R2");
    expect_val(rsp_rdata, 64'h00223344, "R2 page mask");
    xfer(0, 14'h07E8, 4'd4, 0, "R2");
    xfer(1, 14'h003C, 4'd8, 64'h0102030405060708, "R3");
    xfer(0, 14'h0038, 4'd8, 0, "R3");
    xfer(0, 14'h0000, 4'd8, 0, "R6");

    for (int v = 0; v < 3000; v++) begin
      k = int'($urandom % 8);
      a = 14'($urandom);
      wr = 1'($urandom);
      sz = 4'(1 << ($urandom % 4));
      case (k)
        0: begin a[11:0] = 12'h810; wr = 1'b0; sz = 4'd2; end
        1: a[11] = 1'b1;
        2: begin a[11:0] = 12'h011; wr = 1'b1; sz = 4'd1; end
        default: begin
          a[11] = 1'b0;
          if ($urandom % 2) sz = ($urandom % 2) ? 4'd4 : 4'd8;
        end
      endcase
      xfer(wr, a, sz, {$urandom, $urandom}, tag_of(wr, a, sz));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule